// File: doc/BRIEF.md
# Bidirectional Gray Code Counter

This block is a three-bit synchronous counter whose state walks the reflected Gray code cycle. A single direction input picks whether the next counting edge moves forward or backward through the cycle. A count enable gates every step. All state bits are clocked together. The next state is formed combinationally from the present code and the direction bit, so exactly one bit of the output flips on each counting edge.

A wrap flag reports that the counter is at the point where the next counting step closes the cycle in the selected direction. Control pins are plain levels. The block carries no data stream, so it has no handshake.

Top module: `gray_updown_counter`

## Requirements
- R1: With cnt_en high and dir_up high, each rising clock edge moves code along the cycle 000, 001, 011, 010, 110, 111, 101, 100.
- R2: When rst is high at a rising edge, code becomes 000 on that edge, whatever cnt_en and dir_up are.
- R3: When cnt_en is low and rst is low, code keeps its value across the edge for either level of dir_up.
- R4: Every enabled step changes exactly one bit of code.
- R5: With cnt_en high and dir_up low, code moves through the same cycle in reverse order, and 000 steps to 100.
- R6: Counting up from 100 returns code to 000.
- R7: wrap_flag is high exactly when dir_up is high and code is 100, or when dir_up is low and code is 000. It follows these inputs with no clock delay and does not depend on cnt_en.
- R8: A change of dir_up between two enabled edges takes effect on the very next edge, so the counter retraces the code it just left.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to 000 |
| cnt_en | input | 1 | Count enable; the state holds when it is low |
| dir_up | input | 1 | 1 = forward through the cycle, 0 = backward |
| code | output | 3 | Present Gray code state |
| wrap_flag | output | 1 | High at the last code before the wrap in the selected direction |

## Verification
The properties assume that rst is held high across the first clock edge, so every check that looks one cycle back starts from the 000 state. They also assume that cnt_en, dir_up and rst are stable around each rising edge. The bench drives these inputs only on falling edges, and it starts with reset asserted. It then mixes long runs in both directions with direction flips, idle cycles and a reset in the middle of counting. The assertions therefore see the full cycle in both directions and every hold case.

// File: rtl/gray_cnt_pkg.sv
package gray_cnt_pkg;
  localparam int CODE_W = 3;
  typedef logic [CODE_W-1:0] code_t;
  localparam code_t BASE_CODE = '0;
  localparam code_t TOP_CODE  = code_t'(1) << (CODE_W - 1);
endpackage

// File: rtl/gray_step_logic.sv
// Next-state logic: flips a single bit chosen from the parity of the
// present code and the direction.
module gray_step_logic
  import gray_cnt_pkg::*;
(
  input  code_t cur,
  input  logic  dir_up,
  output code_t nxt
);
  code_t flip;
  logic  par;
  logic  odd_step;
  logic  found;

  always_comb begin
    par      = ^cur;
    // forward: odd parity moves the bit left of the lowest one
    // backward: even parity does
    odd_step = dir_up ? par : ~par;
    flip     = '0;
    found    = 1'b0;
    if (!odd_step) begin
      flip[0] = 1'b1;
    end else begin
      for (int i = 0; i < CODE_W - 1; i++) begin
        if (!found && cur[i]) begin
          flip[i+1] = 1'b1;
          found     = 1'b1;
        end
      end
      if (!found) flip[CODE_W-1] = 1'b1;
    end
  end

  assign nxt = cur ^ flip;
endmodule

// File: rtl/gray_state_reg.sv
module gray_state_reg
  import gray_cnt_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  en,
  input  code_t d,
  output code_t q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= BASE_CODE;
    else if (en) q <= d;
  end
endmodule

// File: rtl/gray_wrap_detect.sv
module gray_wrap_detect
  import gray_cnt_pkg::*;
(
  input  code_t cur,
  input  logic  dir_up,
  output logic  at_wrap
);
  assign at_wrap = dir_up ? (cur == TOP_CODE) : (cur == BASE_CODE);
endmodule

// File: rtl/gray_updown_counter.sv
module gray_updown_counter
  import gray_cnt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_en,
  input  logic              dir_up,
  output logic [CODE_W-1:0] code,
  output logic              wrap_flag
);
  code_t state_q;
  code_t state_d;

  gray_step_logic u_step (
    .cur    (state_q),
    .dir_up (dir_up),
    .nxt    (state_d)
  );

  gray_state_reg u_reg (
    .clk (clk),
    .rst (rst),
    .en  (cnt_en),
    .d   (state_d),
    .q   (state_q)
  );

  gray_wrap_detect u_wrap (
    .cur     (state_q),
    .dir_up  (dir_up),
    .at_wrap (wrap_flag)
  );

  assign code = state_q;
endmodule

// File: rtl/gray_updown_counter_chk.sv
module gray_updown_counter_chk
  import gray_cnt_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              cnt_en,
  input logic              dir_up,
  input logic [CODE_W-1:0] code,
  input logic              wrap_flag
);
  // R2
  reset_zero_chk: assert property (@(posedge clk) rst |=> code == BASE_CODE);

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> code == $past(code));

  // R4
  one_bit_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_en |=> $countones(code ^ $past(code)) == 1);

  // R6
  up_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && dir_up && code == TOP_CODE) |=> code == BASE_CODE);

  // R5
  down_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && !dir_up && code == BASE_CODE) |=> code == TOP_CODE);

  // R7
  flag_next_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && wrap_flag) |=> code == ($past(dir_up) ? BASE_CODE : TOP_CODE));
endmodule

bind gray_updown_counter gray_updown_counter_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .cnt_en    (cnt_en),
  .dir_up    (dir_up),
  .code      (code),
  .wrap_flag (wrap_flag)
);

// File: tb/sim_gray_updown_counter.sv
`timescale 1ns/1ps
module sim_gray_updown_counter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cnt_en = 1'b0;
  logic       dir_up = 1'b1;
  logic [2:0] code;
  logic       wrap_flag;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  typedef struct {
    logic [2:0] exp_code;
    logic [2:0] prev_code;
    bit         stepped;
    string      req;
  } item_t;
  item_t sb[$];

  // Expected model: the cycle as an ordered list and a position in it.
  logic [2:0] cyc [8];
  int pos = 0;

  always #2.5 clk = ~clk;

  gray_updown_counter u0 (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .dir_up(dir_up),
    .code(code), .wrap_flag(wrap_flag)
  );

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Driver: applies one cycle of inputs on a falling edge, checks the
  // combinational flag, then queues the code expected after the next edge.
  task automatic drive(bit r, bit en, bit up, string req);
    item_t it;
    @(negedge clk);
    rst = r; cnt_en = en; dir_up = up;
    #0.5;
    // R7 flag reflects present code and direction
    check("R7", {3'b0, wrap_flag},
          {3'b0, ((up && cyc[pos] == 3'b100) || (!up && cyc[pos] == 3'b000))});
    it.prev_code = cyc[pos];
    if (r) pos = 0;
    else if (en) pos = up ? (pos + 1) % 8 : (pos + 7) % 8;
    it.exp_code = cyc[pos];
    it.stepped  = !r && en;
    it.req      = req;
    sb.push_back(it);
  endtask

  // Monitor: samples shortly after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        check(it.req, {1'b0, code}, {1'b0, it.exp_code});
        // R4 exactly one bit flips on an enabled step
        if (it.stepped)
          check("R4", 4'($countones(code ^ it.prev_code)), 4'd1);
      end
    end
  end

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000) begin
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected<=5000", cycles);
        report();
      end
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) cyc[i] = 3'(i ^ (i >> 1));
    drive(1, 0, 1, "R2");
    drive(1, 1, 0, "R2");
    // R1 full forward cycle, then R6 wrap from 100 to 000
    for (int i = 0; i < 7; i++) drive(0, 1, 1, "R1");
    drive(0, 1, 1, "R6");
    drive(0, 1, 1, "R1");
    // R3 hold with both direction levels
    drive(0, 0, 1, "R3");
    drive(0, 0, 0, "R3");
    drive(0, 0, 1, "R3");
    // R5 backward: from 001 to 000, then 000 to 100, and on
    drive(0, 1, 0, "R5");
    for (int i = 0; i < 9; i++) drive(0, 1, 0, "R5");
    // R8 reverse direction on alternate edges
    for (int i = 0; i < 6; i++) drive(0, 1, i % 2 == 0, "R8");
    for (int i = 0; i < 3; i++) drive(0, 1, 1, "R8");
    // R2 reset in the middle of counting
    drive(1, 1, 1, "R2");
    drive(0, 1, 0, "R5");
    drive(0, 0, 0, "R3");
    for (int i = 0; i < 20; i++) drive(0, (i % 3) != 0, (i % 5) < 3, "R4");
    drive(0, 0, 1, "R3");
    repeat (3) @(negedge clk);
    done = 1;
    report();
  end
endmodule